// File: doc/BRIEF.md
# Element-Resizing Vector Add/Subtract Unit

This unit adds or subtracts two 128-bit vectors whose element width changes between the operands and the result. In the long form, both operands supply narrow elements that are extended to double width before the arithmetic, so the result is a full vector of double-width elements. In the wide form, the first operand already holds double-width elements and only the second is extended. The narrowing form combines two vectors of double-width elements and keeps the upper half of each full-width sum or difference, which packs into 64 bits. An extract form truncates each double-width element of the first operand to half width.

A half selector controls where narrow data lives. In the long and wide forms it picks whether the narrow elements are read from the lower or the upper 64 bits of their source. In the narrowing and extract forms it picks the 64-bit half of the destination that receives the packed result. With the upper half selected, the other half is taken from the old destination value. With the lower half selected, the other half is cleared. The result is registered, so it appears one cycle after a valid request.

Top module: `vwn_unit`

## Requirements
- R1: Mode 0 (long): each narrow element of `src_a` and `src_b` is extended to twice its width. Result element i is the sum, or the difference a minus b when `subtract`=1, taken modulo the double width and placed at bit i*2W, where W = 8 << `esize`.
- R2: Mode 1 (wide): `src_a` is read directly as double-width elements and only the narrow elements of `src_b` are extended. The result is a+b, or a-b when `subtract`=1, per double-width element.
- R3: In modes 0 and 1, `upper_sel`=1 takes the narrow elements from bits 127:64 of their source, and `upper_sel`=0 takes them from bits 63:0.
- R4: Mode 2 (narrowing high): for each double-width element pair of `src_a` and `src_b`, narrow element i is the upper half of the full-width sum or difference. The narrow elements are packed at bit i*W into a 64-bit vector.
- R5: Mode 3 (extract): narrow element i is the low W bits of double-width element i of `src_a`. In this mode `src_b` and `subtract` have no effect on the result.
- R6: In modes 2 and 3 with `upper_sel`=0, the packed vector occupies result bits 63:0 and bits 127:64 are zero.
- R7: In modes 2 and 3 with `upper_sel`=1, the packed vector occupies result bits 127:64 and bits 63:0 equal `dst_old`[63:0].
- R8: When `is_signed`=1, extension copies the narrow element's top bit; otherwise it fills with zeros. `is_signed` has no effect in modes 2 and 3.
- R9: `out_valid` equals `in_valid` delayed by one clock. `result` is updated one clock after a cycle with `in_valid`=1 and holds its value after a cycle with `in_valid`=0.
- R10: `esize` = 3 is reserved and gives an all-zero result.
- R11: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 long, 1 wide, 2 narrowing high, 3 extract |
| subtract | input | 1 | 1 subtracts b from a, 0 adds |
| upper_sel | input | 1 | Selects the upper 64-bit half for narrow data |
| is_signed | input | 1 | Sign-extend (1) or zero-extend (0) |
| esize | input | 2 | Narrow element width: 0 for 8, 1 for 16, 2 for 32, 3 reserved |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| dst_old | input | 128 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Registered result vector |

## Verification
In the narrowing forms with upper-half selection, two functions meet in one output word: freshly computed narrow lanes go into the upper half, while the lower half passes the old destination through. Random requests with random `dst_old`, mode and selector provoke this often. Each 128-bit result is compared with a bench model that builds both halves separately, so a write landing in the wrong half or a merge slip shows up in the comparison. In the same way, sign extension meets upper-half reading whenever the upper lanes carry negative values, and the model checks the top bits of every double-width lane.

// File: rtl/vwn_pkg.sv
package vwn_pkg;

   typedef enum logic [1:0] {
      VM_LONG      = 2'd0,
      VM_WIDE      = 2'd1,
      VM_NARROW_HI = 2'd2,
      VM_EXTRACT   = 2'd3
   } vwn_mode_e;

   localparam int unsigned VWN_MIN_EW    = 8;
   localparam int unsigned VWN_NUM_SIZES = 3;

endpackage

// File: rtl/vwn_widen_bank.sv
// Long and wide forms for one narrow element width NW.
module vwn_widen_bank #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned NW    = 8
) (
   input  logic [VEC_W-1:0] a_i,
   input  logic [VEC_W-1:0] b_i,
   input  logic             upper_i,
   input  logic             signed_i,
   input  logic             wide_form_i,
   input  logic             sub_i,
   output logic [VEC_W-1:0] res_o
);
   localparam int unsigned HALF  = VEC_W / 2;
   localparam int unsigned WW    = 2 * NW;
   localparam int unsigned LANES = HALF / NW;

   if ((HALF % NW) != 0) begin : g_bad_nw
      $error("vwn_widen_bank: NW must divide half the vector width");
   end

   logic [HALF-1:0] a_half;
   logic [HALF-1:0] b_half;

   // Narrow operands come from the selected 64-bit half of the source.
   assign a_half = upper_i ? a_i[VEC_W-1:HALF] : a_i[HALF-1:0];
   assign b_half = upper_i ? b_i[VEC_W-1:HALF] : b_i[HALF-1:0];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [NW-1:0] a_nar;
      logic [NW-1:0] b_nar;
      logic [WW-1:0] a_ext;
      logic [WW-1:0] b_ext;
      logic [WW-1:0] a_op;

      assign a_nar = a_half[l*NW +: NW];
      assign b_nar = b_half[l*NW +: NW];
      assign a_ext = {{NW{signed_i & a_nar[NW-1]}}, a_nar};
      assign b_ext = {{NW{signed_i & b_nar[NW-1]}}, b_nar};
      assign a_op  = wide_form_i ? a_i[l*WW +: WW] : a_ext;
      assign res_o[l*WW +: WW] = sub_i ? (a_op - b_ext) : (a_op + b_ext);
   end

endmodule

// File: rtl/vwn_narrow_bank.sv
// Narrowing-high and extract forms for one narrow element width NW.
module vwn_narrow_bank #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned NW    = 8
) (
   input  logic [VEC_W-1:0]   a_i,
   input  logic [VEC_W-1:0]   b_i,
   input  logic               extract_i,
   input  logic               sub_i,
   output logic [VEC_W/2-1:0] nar_o
);
   localparam int unsigned HALF  = VEC_W / 2;
   localparam int unsigned WW    = 2 * NW;
   localparam int unsigned LANES = HALF / NW;

   if ((HALF % NW) != 0) begin : g_bad_nw
      $error("vwn_narrow_bank: NW must divide half the vector width");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WW-1:0] a_w;
      logic [WW-1:0] b_w;
      logic [WW-1:0] full;

      assign a_w  = a_i[l*WW +: WW];
      assign b_w  = b_i[l*WW +: WW];
      assign full = sub_i ? (a_w - b_w) : (a_w + b_w);
      assign nar_o[l*NW +: NW] = extract_i ? a_w[NW-1:0] : full[WW-1:NW];
   end

endmodule

// File: rtl/vwn_unit.sv
module vwn_unit
   import vwn_pkg::*;
#(
   parameter int unsigned VEC_W     = 128,
   parameter int unsigned MIN_EW    = VWN_MIN_EW,
   parameter int unsigned NUM_SIZES = VWN_NUM_SIZES,
   localparam int unsigned ES_W     = $clog2(NUM_SIZES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       mode,
   input  logic             subtract,
   input  logic             upper_sel,
   input  logic             is_signed,
   input  logic [ES_W-1:0]  esize,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] dst_old,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int unsigned HALF   = VEC_W / 2;
   localparam int unsigned MAX_NW = MIN_EW << (NUM_SIZES - 1);

   if ((VEC_W % 2) != 0 || (HALF % MAX_NW) != 0) begin : g_bad_width
      $error("vwn_unit: half vector width must be a multiple of the largest narrow element");
   end
   if (NUM_SIZES < 1) begin : g_bad_sizes
      $error("vwn_unit: at least one element size is required");
   end

   vwn_mode_e        op;
   logic             is_narrow;
   logic [VEC_W-1:0] wid_res [NUM_SIZES];
   logic [HALF-1:0]  nar_res [NUM_SIZES];
   logic [VEC_W-1:0] nxt;

   assign op        = vwn_mode_e'(mode);
   assign is_narrow = (op == VM_NARROW_HI) || (op == VM_EXTRACT);

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vwn_widen_bank #(.VEC_W(VEC_W), .NW(MIN_EW << s)) i_widen (
         .a_i        (src_a),
         .b_i        (src_b),
         .upper_i    (upper_sel),
         .signed_i   (is_signed),
         .wide_form_i(op == VM_WIDE),
         .sub_i      (subtract),
         .res_o      (wid_res[s])
      );
      vwn_narrow_bank #(.VEC_W(VEC_W), .NW(MIN_EW << s)) i_narrow (
         .a_i      (src_a),
         .b_i      (src_b),
         .extract_i(op == VM_EXTRACT),
         .sub_i    (subtract),
         .nar_o    (nar_res[s])
      );
   end

   always_comb begin
      nxt = '0;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (int'(esize) == s) begin
            if (is_narrow) begin
               nxt = upper_sel ? {nar_res[s], dst_old[HALF-1:0]}
                               : {{HALF{1'b0}}, nar_res[s]};
            end else begin
               nxt = wid_res[s];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

   // R9
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && !out_valid));

   // R7
   keep_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[1] && upper_sel && int'(esize) < NUM_SIZES)
      |=> (result[HALF-1:0] == $past(dst_old[HALF-1:0])));

   // R6
   clear_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[1] && !upper_sel) |=> (result[VEC_W-1:HALF] == '0));

   // R10
   reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && int'(esize) >= NUM_SIZES) |=> (result == '0));

endmodule

// File: tb/test_vwn_unit.sv
`timescale 1ns/1ps
module test_vwn_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   mode = '0;
   logic         subtract = 1'b0;
   logic         upper_sel = 1'b0;
   logic         is_signed = 1'b0;
   logic [1:0]   esize = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [127:0] dst_old = '0;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vwn_unit i_vwn_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .subtract(subtract), .upper_sel(upper_sel), .is_signed(is_signed),
      .esize(esize), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] rand128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   function automatic logic [127:0] model(input logic [1:0] md, input logic sb,
         input logic up, input logic sg, input logic [1:0] es,
         input logic [127:0] a, input logic [127:0] b, input logic [127:0] d);
      logic [127:0] r = '0;
      logic [63:0]  packed_n = '0;
      int nw, ww, lanes;
      logic [63:0] mn, mw, an, bn, ax, bx, v;
      logic [64:0] fa, fb, fs;
      if (es == 2'd3) return '0;
      nw = 8 << es;
      ww = 2 * nw;
      lanes = 64 / nw;
      mn = (64'd1 << nw) - 64'd1;
      mw = (ww == 64) ? {64{1'b1}} : ((64'd1 << ww) - 64'd1);
      if (md < 2) begin
         for (int i = 0; i < lanes; i++) begin
            an = ((up ? a[127:64] : a[63:0]) >> (i * nw)) & mn;
            bn = ((up ? b[127:64] : b[63:0]) >> (i * nw)) & mn;
            ax = (sg && an[nw-1]) ? (an | ~mn) : an;
            bx = (sg && bn[nw-1]) ? (bn | ~mn) : bn;
            if (md == 2'd1) ax = 64'(a >> (i * ww)) & mw;
            v = (sb ? (ax - bx) : (ax + bx)) & mw;
            r = r | ({64'd0, v} << (i * ww));
         end
         return r;
      end
      for (int i = 0; i < lanes; i++) begin
         fa = {1'b0, 64'(a >> (i * ww)) & mw};
         fb = {1'b0, 64'(b >> (i * ww)) & mw};
         fs = sb ? (fa - fb) : (fa + fb);
         if (md == 2'd3) v = fa[63:0] & mn;
         else            v = 64'(fs >> nw) & mn;
         packed_n = packed_n | (v << (i * nw));
      end
      return up ? {packed_n, d[63:0]} : {64'd0, packed_n};
   endfunction

   function automatic string tag_of(input logic [1:0] md, input logic up,
                                    input logic [1:0] es);
      if (es == 2'd3) return "R10";
      case (md)
         2'd0: return up ? "R1/R3" : "R1";
         2'd1: return up ? "R2/R3" : "R2";
         2'd2: return up ? "R4/R7" : "R4/R6";
         default: return up ? "R5/R7" : "R5/R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [127:0] got,
                        input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Drive at a falling edge, sample at the next falling edge.
   task automatic run_op(input logic [1:0] md, input logic sb, input logic up,
         input logic sg, input logic [1:0] es, input logic [127:0] a,
         input logic [127:0] b, input logic [127:0] d, input string req);
      logic [127:0] exp;
      mode = md; subtract = sb; upper_sel = up; is_signed = sg; esize = es;
      src_a = a; src_b = b; dst_old = d; in_valid = 1'b1;
      exp = model(md, sb, up, sg, es, a, b, d);
      @(negedge clk);
      check(req, result, exp);
      check("R9 valid", {127'd0, out_valid}, 128'd1);
   endtask

   initial begin
      logic [127:0] saved;
      logic [127:0] ones;
      logic [127:0] pa;
      logic [127:0] pd;
      void'($urandom(32'h5eed_0717));
      ones = {128{1'b1}};
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 out_valid", {127'd0, out_valid}, 128'd0);
      check("R11 result", result, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 signed versus unsigned extension, 32-bit narrow lanes
      run_op(2'd0, 1'b0, 1'b0, 1'b1, 2'd2, ones, ones, '0, "R8 signed");
      run_op(2'd0, 1'b0, 1'b0, 1'b0, 2'd2, ones, ones, '0, "R8 unsigned");
      run_op(2'd1, 1'b1, 1'b1, 1'b1, 2'd0, '0, ones, '0, "R8/R3 wide");
      // R3 upper lanes with negative bytes
      pa = {64'h80FF_7F01_8000_00FF, 64'h0};
      run_op(2'd0, 1'b1, 1'b1, 1'b1, 2'd0, pa, ~pa, '0, "R3 upper signed");
      // R4 carry out of the top wide lane
      run_op(2'd2, 1'b0, 1'b0, 1'b0, 2'd2, ones, ones, '0, "R4 carry");
      run_op(2'd2, 1'b1, 1'b0, 1'b1, 2'd1, '0, {8{16'h0001}}, '0, "R4 borrow");
      // R7 merge with old destination
      pd = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      run_op(2'd2, 1'b0, 1'b1, 1'b0, 2'd0, rand128(), rand128(), pd, "R7 merge");
      run_op(2'd3, 1'b0, 1'b0, 1'b0, 2'd1, rand128(), '0, pd, "R6 extract low");
      // R5 src_b and subtract have no effect in extract mode
      pa = rand128();
      run_op(2'd3, 1'b0, 1'b1, 1'b0, 2'd2, pa, '0, pd, "R5 b=0");
      run_op(2'd3, 1'b1, 1'b1, 1'b1, 2'd2, pa, ones, pd, "R5 b=ones sub");
      // R10 reserved size
      run_op(2'd0, 1'b0, 1'b0, 1'b0, 2'd3, ones, ones, ones, "R10");
      run_op(2'd2, 1'b0, 1'b1, 1'b0, 2'd3, ones, ones, ones, "R10 narrow");

      // R9 hold while idle
      run_op(2'd1, 1'b0, 1'b0, 1'b0, 2'd1, rand128(), rand128(), '0, "R2");
      saved = result;
      in_valid = 1'b0; src_a = rand128(); src_b = rand128(); mode = 2'd2;
      @(negedge clk);
      check("R9 hold result", result, saved);
      check("R9 idle valid", {127'd0, out_valid}, 128'd0);

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] md;
         logic [1:0] es;
         logic up;
         md = 2'($urandom_range(0, 3));
         es = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         up = 1'($urandom());
         run_op(md, 1'($urandom()), up, 1'($urandom()), es,
                rand128(), rand128(), rand128(), tag_of(md, up, es));
      end

      // R11 asynchronous reset clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 re-reset result", result, 128'd0);
      check("R11 re-reset valid", {127'd0, out_valid}, 128'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule